// File: doc/BRIEF.md
# Trigger-Latency Hit Pipeline with Event Derandomizer

This block sits behind a 64-channel front end. Every bunch clock it takes one hit word, clears the bits of disabled channels with a per-channel enable mask, and writes the result into a circular latency buffer. A first-level trigger decision arrives a programmable number of cycles later for each word. An accept copies the delayed word into a 256-entry derandomizing FIFO. A reject leaves the word to be overwritten.

Each stored event is 71 bits wide. Above the 64 data bits it carries low-order bits of a local bunch-crossing counter and a local event counter, so that a downstream checker can compare alignment across boards. A downstream serializer sees the oldest stored event at the output and removes it with a read request. An accept that finds the FIFO full is lost and sets a sticky overflow flag.

Top module: `trig_pipe_derand`

## Requirements
- R1: While `rst` is high at a rising edge (synchronous reset), the counters, the latency buffer, the FIFO and the overflow flag are cleared. The enable mask returns to all ones. After reset `evValid`, `derandFull` and `overflow` read 0.
- R2: The word stored for a cycle is `hitWord & mask`, using the mask in force during that cycle. A write through `maskWrEn`/`maskWrData` takes effect from the next cycle.
- R3: Number the cycles 0, 1, 2 … from the first cycle with `rst` low. With `latencySel` = N, an `l1Accept` in cycle c selects the masked word of cycle c−(N+1). N ranges over 0..255, giving a latency of 1..256 cycles.
- R4: A cycle with `l1Accept` low stores nothing in the FIFO.
- R5: A stored event is laid out as follows. Bits 70:67 hold the low 4 bits of the cycle number of the accept. Bits 66:64 hold the low 3 bits of the number of accepts since reset that came before it. Bits 63:0 hold the selected word.
- R6: The FIFO holds up to 256 events in accept order. `derandFull` is high exactly when 256 events are stored.
- R7: `evData` shows the oldest stored event and `evValid` is high whenever the FIFO is not empty. `readReq` removes that event at the next edge. `readReq` on an empty FIFO has no effect.
- R8: An accept in a cycle that starts with the FIFO full stores nothing, even if `readReq` pops in the same cycle, and it sets `overflow`. `overflow` stays set until reset. The event count still advances for that accept.
- R9: An accept that selects a cycle before the last reset, or before cycle 0, returns an all-zero data word.
- R10: The largest setting, `latencySel` = 255, selects the word from exactly 256 cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst | input | 1 | Synchronous reset, active high |
| hitWord | input | 64 | Front-end hit word for this cycle |
| maskWrEn | input | 1 | Load the channel enable mask |
| maskWrData | input | 64 | New mask value, 1 = channel enabled |
| latencySel | input | 8 | Trigger latency minus one, in cycles |
| l1Accept | input | 1 | Trigger decision for the aligned word, 1 = accept |
| readReq | input | 1 | Remove the oldest stored event |
| evValid | output | 1 | FIFO holds at least one event |
| evData | output | 71 | Oldest stored event: tags and data |
| derandFull | output | 1 | FIFO holds 256 events |
| overflow | output | 1 | Sticky: an accept was dropped because the FIFO was full |

## Verification
A write pointer that slips against the cycle count, or a wrongly computed read offset, appears in the data field of the very first accept that reaches the output. Counter faults appear in the tag bits of that same event. A FIFO pointer or fill-count error appears within one cycle as a wrong `evValid`, a wrong `derandFull` or a mis-ordered `evData`. A faulty overflow path appears on the cycle after the first accept into a full FIFO. Because the bench model is compared on every clock, each of these faults is caught at the first cycle where it reaches a port.

// File: rtl/trig_pipe_pkg.sv
package trig_pipe_pkg;
  parameter int unsigned TP_DATA_W     = 64;
  parameter int unsigned TP_PIPE_DEPTH = 256;
  parameter int unsigned TP_FIFO_DEPTH = 256;
  parameter int unsigned TP_BX_TAG_W   = 4;
  parameter int unsigned TP_EV_TAG_W   = 3;
  parameter int unsigned TP_CNT_W      = 12;

  localparam int unsigned TP_PIPE_AW = $clog2(TP_PIPE_DEPTH);
  localparam int unsigned TP_FIFO_AW = $clog2(TP_FIFO_DEPTH);
  localparam int unsigned TP_TAG_W   = TP_BX_TAG_W + TP_EV_TAG_W;
  localparam int unsigned TP_EV_W    = TP_DATA_W + TP_TAG_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic [TP_PIPE_AW-1:0] pipeWrAddr;
    logic [TP_PIPE_AW-1:0] pipeRdAddr;
    logic                  pushEv;
    logic [TP_FIFO_AW-1:0] fifoWrAddr;
    logic [TP_FIFO_AW-1:0] fifoRdAddr;
    logic [TP_TAG_W-1:0]   tag;
  } dpStrobes_t;
endpackage

// File: rtl/trig_pipe_ctrl.sv
module trig_pipe_ctrl
  import trig_pipe_pkg::*;
#(
  parameter int unsigned PIPE_DEPTH = TP_PIPE_DEPTH,
  parameter int unsigned FIFO_DEPTH = TP_FIFO_DEPTH,
  parameter int unsigned CNT_W      = TP_CNT_W,
  parameter int unsigned BX_TAG_W   = TP_BX_TAG_W,
  parameter int unsigned EV_TAG_W   = TP_EV_TAG_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [$clog2(PIPE_DEPTH)-1:0] latencySel,
  input  logic                          l1Accept,
  input  logic                          readReq,
  output dpStrobes_t                    strobes,
  output logic                          evValid,
  output logic                          derandFull,
  output logic                          overflow
);
  localparam int unsigned PA = $clog2(PIPE_DEPTH);
  localparam int unsigned FA = $clog2(FIFO_DEPTH);

  logic [PA-1:0]    wrPtr;
  logic [CNT_W-1:0] bxCnt;
  logic [CNT_W-1:0] evCnt;
  logic [FA:0]      fWr;
  logic [FA:0]      fRd;
  logic [FA:0]      fCount;
  logic             isFull;
  logic             isEmpty;
  logic             doPush;
  logic             doPop;
  logic             ovfQ;

  assign fCount  = fWr - fRd;
  assign isFull  = (fCount == (FA+1)'(FIFO_DEPTH));
  assign isEmpty = (fWr == fRd);
  assign doPush  = l1Accept && !isFull;
  assign doPop   = readReq && !isEmpty;

  // Bunch-crossing counter and circular write pointer advance every cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      bxCnt <= '0;
    end else begin
      wrPtr <= wrPtr + PA'(1);
      bxCnt <= bxCnt + CNT_W'(1);
    end
  end

  // Event counter advances on every accept, stored or dropped
  always_ff @(posedge clk) begin
    if (rst)           evCnt <= '0;
    else if (l1Accept) evCnt <= evCnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fWr <= '0;
      fRd <= '0;
    end else begin
      if (doPush) fWr <= fWr + (FA+1)'(1);
      if (doPop)  fRd <= fRd + (FA+1)'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      ovfQ <= 1'b0;
    else if (l1Accept && isFull)  ovfQ <= 1'b1;
  end

  always_comb begin
    strobes.pipeWrAddr = wrPtr;
    strobes.pipeRdAddr = wrPtr - latencySel - PA'(1);
    strobes.pushEv     = doPush;
    strobes.fifoWrAddr = fWr[FA-1:0];
    strobes.fifoRdAddr = fRd[FA-1:0];
    strobes.tag        = {bxCnt[BX_TAG_W-1:0], evCnt[EV_TAG_W-1:0]};
  end

  assign evValid    = !isEmpty;
  assign derandFull = isFull;
  assign overflow   = ovfQ;
endmodule

// File: rtl/trig_pipe_datapath.sv
module trig_pipe_datapath
  import trig_pipe_pkg::*;
#(
  parameter int unsigned DATA_W     = TP_DATA_W,
  parameter int unsigned PIPE_DEPTH = TP_PIPE_DEPTH,
  parameter int unsigned FIFO_DEPTH = TP_FIFO_DEPTH,
  parameter int unsigned TAG_W      = TP_TAG_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DATA_W-1:0]       hitWord,
  input  logic                    maskWrEn,
  input  logic [DATA_W-1:0]       maskWrData,
  input  dpStrobes_t              strobes,
  output logic [DATA_W+TAG_W-1:0] evData
);
  localparam int unsigned EV_W = DATA_W + TAG_W;

  logic [DATA_W-1:0] chanMask;
  logic [DATA_W-1:0] maskedWord;
  logic [DATA_W-1:0] pipeMem [PIPE_DEPTH];
  logic [EV_W-1:0]   fifoMem [FIFO_DEPTH];
  logic [DATA_W-1:0] delayedWord;

  always_ff @(posedge clk) begin
    if (rst)           chanMask <= '1;
    else if (maskWrEn) chanMask <= maskWrData;
  end

  assign maskedWord = hitWord & chanMask;

  // Latency buffer: cleared on reset so early decisions see zero words
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(PIPE_DEPTH); i++) pipeMem[i] <= '0;
    end else begin
      pipeMem[strobes.pipeWrAddr] <= maskedWord;
    end
  end

  // Read before write: at full latency the slot still holds the old word
  assign delayedWord = pipeMem[strobes.pipeRdAddr];

  always_ff @(posedge clk) begin
    if (strobes.pushEv) fifoMem[strobes.fifoWrAddr] <= {strobes.tag, delayedWord};
  end

  assign evData = fifoMem[strobes.fifoRdAddr];
endmodule

// File: rtl/trig_pipe_derand.sv
module trig_pipe_derand
  import trig_pipe_pkg::*;
#(
  parameter int unsigned DATA_W     = TP_DATA_W,
  parameter int unsigned PIPE_DEPTH = TP_PIPE_DEPTH,
  parameter int unsigned FIFO_DEPTH = TP_FIFO_DEPTH,
  parameter int unsigned LAT_W      = $clog2(PIPE_DEPTH),
  parameter int unsigned EV_W       = DATA_W + TP_TAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] hitWord,
  input  logic              maskWrEn,
  input  logic [DATA_W-1:0] maskWrData,
  input  logic [LAT_W-1:0]  latencySel,
  input  logic              l1Accept,
  input  logic              readReq,
  output logic              evValid,
  output logic [EV_W-1:0]   evData,
  output logic              derandFull,
  output logic              overflow
);
  dpStrobes_t strobes;

  trig_pipe_ctrl #(
    .PIPE_DEPTH(PIPE_DEPTH),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .latencySel (latencySel),
    .l1Accept   (l1Accept),
    .readReq    (readReq),
    .strobes    (strobes),
    .evValid    (evValid),
    .derandFull (derandFull),
    .overflow   (overflow)
  );

  trig_pipe_datapath #(
    .DATA_W    (DATA_W),
    .PIPE_DEPTH(PIPE_DEPTH),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .hitWord    (hitWord),
    .maskWrEn   (maskWrEn),
    .maskWrData (maskWrData),
    .strobes    (strobes),
    .evData     (evData)
  );
endmodule

// File: rtl/trig_pipe_derand_chk.sv
module trig_pipe_derand_chk (
  input logic clk,
  input logic rst,
  input logic l1Accept,
  input logic readReq,
  input logic evValid,
  input logic derandFull,
  input logic overflow
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!evValid && !overflow && !derandFull));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (l1Accept && derandFull) |=> overflow);

  // R6
  full_valid_chk: assert property (@(posedge clk) disable iff (rst)
    derandFull |-> evValid);

  // R7
  empty_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (!evValid && !l1Accept) |=> !evValid);

  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (derandFull && !readReq) |=> derandFull);
endmodule

bind trig_pipe_derand trig_pipe_derand_chk chk_i (.*);

// File: tb/trig_pipe_derand_test.sv
module trig_pipe_derand_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] hitWord;
  logic        maskWrEn;
  logic [63:0] maskWrData;
  logic [7:0]  latencySel;
  logic        l1Accept;
  logic        readReq;
  logic        evValid;
  logic [70:0] evData;
  logic        derandFull;
  logic        overflow;

  always #10 clk = ~clk;

  trig_pipe_derand uut (.*);

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  // Behavioural reference model
  logic [63:0] hist [int];
  logic [63:0] mMask;
  logic [70:0] q [$];
  int cyc, mEv;
  bit mOvf;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [70:0] act, input logic [70:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkOutputs();
    chk(evValid === (q.size() != 0), curReq, "evValid", 71'(evValid), 71'(q.size() != 0));
    chk(derandFull === (q.size() == 256), curReq, "derandFull", 71'(derandFull), 71'(q.size() == 256));
    chk(overflow === mOvf, curReq, "overflow", 71'(overflow), 71'(mOvf));
    if (q.size() != 0) chk(evData === q[0], curReq, "evData", evData, q[0]);
  endtask

  // One cycle: check state, apply inputs, advance the model
  task automatic tick(input logic [63:0] hit, input bit mw, input logic [63:0] md,
                      input logic [7:0] lat, input bit acc, input bit rr);
    bit fullPre;
    int idx;
    logic [63:0] w;
    checkOutputs();
    hitWord = hit; maskWrEn = mw; maskWrData = md;
    latencySel = lat; l1Accept = acc; readReq = rr;
    hist[cyc] = hit & mMask;
    if (hist.exists(cyc - 300)) hist.delete(cyc - 300);
    if (mw) mMask = md;
    fullPre = (q.size() == 256);
    if (rr && q.size() != 0) void'(q.pop_front());
    if (acc) begin
      idx = cyc - (int'(lat) + 1);
      w = (idx >= 0 && hist.exists(idx)) ? hist[idx] : 64'h0;
      if (fullPre) mOvf = 1'b1;
      else q.push_back({4'(cyc), 3'(mEv), w});
      mEv++;
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    hitWord = '0; maskWrEn = 1'b0; maskWrData = '0;
    latencySel = '0; l1Accept = 1'b0; readReq = 1'b0;
    repeat (3) @(negedge clk);
    hist.delete(); q.delete();
    cyc = 0; mEv = 0; mOvf = 1'b0; mMask = '1;
    // R1: outputs cleared while reset is held
    checkOutputs();
    rst = 1'b0;
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    curReq = "R1";
    doReset();
    // R1: mask is all ones after reset, so full words pass
    for (int i = 0; i < 6; i++) tick('1, 0, '0, 8'd0, i > 0, 1);

    curReq = "R2";
    tick('1, 1, 64'h00FF_0F0F_F0F0_1234, 8'd0, 1, 1);
    tick('1, 0, '0, 8'd0, 1, 1);
    tick(rnd64(), 1, 64'hFFFF_0000_FFFF_0000, 8'd0, 1, 1);
    for (int i = 0; i < 10; i++) tick(rnd64(), i == 4, rnd64(), 8'd0, 1, i % 2 == 0);
    tick(rnd64(), 1, '1, 8'd0, 0, 1);

    curReq = "R3";
    for (int i = 0; i < 60; i++) tick(rnd64(), 0, '0, 8'd4, $urandom_range(0, 2) == 0, 1);
    for (int i = 0; i < 60; i++) tick(rnd64(), 0, '0, 8'd37, $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1);

    curReq = "R5";
    for (int i = 0; i < 40; i++) tick(rnd64(), 0, '0, 8'd9, 1, $urandom_range(0, 1) == 1);
    for (int i = 0; i < 60; i++) tick(rnd64(), 0, '0, 8'd9, 0, 1);

    curReq = "R4";
    for (int i = 0; i < 40; i++) tick(rnd64(), 0, '0, 8'd2, 0, 0);

    curReq = "R10";
    for (int i = 0; i < 300; i++) tick(rnd64(), 0, '0, 8'd255, (i % 23) == 0, 1);

    curReq = "R6";
    for (int i = 0; i < 256; i++) tick(rnd64(), 0, '0, 8'd12, 1, 0);
    for (int i = 0; i < 5; i++) tick(rnd64(), 0, '0, 8'd12, 0, 0);

    curReq = "R8";
    for (int i = 0; i < 4; i++) tick(rnd64(), 0, '0, 8'd12, 1, 0);
    tick(rnd64(), 0, '0, 8'd12, 1, 1);
    for (int i = 0; i < 6; i++) tick(rnd64(), 0, '0, 8'd12, 1, i % 2 == 0);

    curReq = "R7";
    for (int i = 0; i < 270; i++) tick(rnd64(), 0, '0, 8'd12, 0, 1);
    for (int i = 0; i < 5; i++) tick(rnd64(), 0, '0, 8'd12, 0, 1);
    tick(rnd64(), 0, '0, 8'd12, 1, 1);
    for (int i = 0; i < 20; i++) tick(rnd64(), 0, '0, 8'd12, 0, 1);

    curReq = "R9";
    for (int i = 0; i < 30; i++) tick(rnd64() | 64'h1, 0, '0, 8'd0, 0, 0);
    doReset();
    for (int i = 0; i < 8; i++) tick(rnd64(), 0, '0, 8'd200, 1, i > 3);
    for (int i = 0; i < 12; i++) tick(rnd64(), 0, '0, 8'd200, 0, 1);
    checkOutputs();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule